// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a register-mapped general-purpose I/O controller for a pin count that is a whole multiple of 32. The default is 64 pins, and 96 is the other intended size. Software drives the pins through a plain 32-bit register port. It chooses each pin's direction, and it raises or lowers the output latch by writing ones to separate set and clear words. It can read back the synchronised pin levels.

Each input pin passes through a two-flop synchroniser. A pin's rising and falling transitions can be enabled separately, and an enabled transition latches a sticky status bit. Software clears a status bit by writing a one to it. A transition that lands in the same cycle as that clear is kept. A single interrupt output is high whenever any status bit is set.

The registers are grouped by feature. Each feature occupies one 32-bit word per 32 pins, so the address stride between features grows with the pin count.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous reset, `pin_oe`, `pin_out`, `irq` and `reg_rdata` are all zero, and every direction, enable and status bit reads back as zero.
- R2: A register word sits at byte address (feature × WPF + word) × 4, where WPF = NUM_PINS/32. The features are numbered 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable and 6 edge status. Pin p uses word p/32, bit p mod 32. An access whose address has bits [1:0] non-zero, or that falls beyond the last word, is ignored and reads zero.
- R3: The direction word is read/write. Bit value 1 makes the pin an output and is driven on `pin_oe` from the cycle after the write.
- R4: Writing the set word forces to 1 the output-latch bits where the write data has ones. The other latch bits keep their value. The set word reads as zero.
- R5: Writing the clear word forces to 0 the output-latch bits where the write data has ones. The other latch bits keep their value. The clear word reads as zero.
- R6: The level word returns the pin inputs after two register stages. Writes to it change nothing.
- R7: A 0→1 change of a synchronised pin sets its status bit when its rising enable is 1. A 1→0 change sets it when its falling enable is 1. With both enables set, either change sets the bit.
- R8: A status bit stays set until a write of 1 to that bit of the edge-status word. Writing 0 leaves the bit unchanged.
- R9: If an enabled transition is detected in the same cycle as a write that clears its status bit, the bit stays set.
- R10: `irq` is high exactly when at least one status bit is set, and it updates in the same cycle as the status bits.
- R11: The output latch keeps its value while the pin is an input. Switching the pin to output drives the value last written.
- R12: A read returns the addressed word on `reg_rdata` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_PINS | Pin inputs, asynchronous |
| pin_oe | output | NUM_PINS | Output enable per pin (direction) |
| pin_out | output | NUM_PINS | Output latch value per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
A corrupted direction or output-latch bit appears on `pin_oe` or `pin_out` one cycle after the write that should have set it. A missing or stray status bit shows up on `irq`, and in the edge-status readback, three cycles after the pin changes. A wrong word decode shows up as a mismatch on the next register read, which returns data one cycle after the address. The cycle in which a clear coincides with a detected transition is exercised directly, because a lost event there is otherwise invisible until an interrupt never arrives.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_FEAT   = 7;
  localparam int FEAT_LEVEL = 0;
  localparam int FEAT_DIR   = 1;
  localparam int FEAT_SET   = 2;
  localparam int FEAT_CLR   = 3;
  localparam int FEAT_RISE  = 4;
  localparam int FEAT_FALL  = 5;
  localparam int FEAT_STAT  = 6;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  output logic [W-1:0] level,
  output logic [W-1:0] rise_pulse,
  output logic [W-1:0] fall_pulse
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level      = sync_q;
  assign rise_pulse = sync_q & ~prev_q;
  assign fall_pulse = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_bank_word.sv
module gpio_bank_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         sel_dir,
  input  logic         sel_set,
  input  logic         sel_clr,
  input  logic         sel_rise,
  input  logic         sel_fall,
  input  logic         sel_stat,
  input  logic [W-1:0] rise_pulse,
  input  logic [W-1:0] fall_pulse,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rise_en_q,
  output logic [W-1:0] fall_en_q,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_d
);
  logic [W-1:0] clr_mask, hits, set_mask, drop_mask;

  assign set_mask  = (wr_en && sel_set) ? wdata : '0;
  assign drop_mask = (wr_en && sel_clr) ? wdata : '0;
  assign clr_mask  = (wr_en && sel_stat) ? wdata : '0;
  assign hits      = (rise_pulse & rise_en_q) | (fall_pulse & fall_en_q);
  assign status_d  = (status_q & ~clr_mask) | hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '0;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      status_q  <= '0;
    end else begin
      if (wr_en && sel_dir)  dir_q     <= wdata;
      if (wr_en && sel_rise) rise_en_q <= wdata;
      if (wr_en && sel_fall) fall_en_q <= wdata;
      out_q    <= (out_q | set_mask) & ~drop_mask;
      status_q <= status_d;
    end
  end

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_dir) |=> (dir_q == $past(wdata))); // R3
  AST_OUT_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_set) |=> ((out_q & $past(wdata)) == $past(wdata))); // R4
  AST_OUT_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_clr) |=> ((out_q & $past(wdata)) == '0)); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0)); // R8
  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|hits) |=> ((status_q & $past(hits)) == $past(hits))); // R9
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                irq
);
  localparam int WPF    = NUM_PINS / WORD_W;
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] word_idx;
  logic              addr_ok;
  logic [WORD_W-1:0] feat_val [NUM_FEAT][WPF];
  logic [WPF-1:0]    stat_any_d, stat_any_q;
  logic [WORD_W-1:0] rd_mux;

  assign word_idx = reg_addr[ADDR_W-1:2];
  assign addr_ok  = (reg_addr[1:0] == 2'b00);

  for (genvar w = 0; w < WPF; w++) begin : g_word
    logic [NUM_FEAT-1:0] sel;
    logic [WORD_W-1:0]   level, rise_p, fall_p, dir_w, out_w, ren_w, fen_w, st_q, st_d;

    for (genvar f = 0; f < NUM_FEAT; f++) begin : g_sel
      localparam logic [WIDX_W-1:0] IDX = WIDX_W'(f * WPF + w);
      assign sel[f] = addr_ok && (word_idx == IDX);
    end

    gpio_bank_sync #(.W(WORD_W)) u_sync (
      .clk(clk), .rst(rst), .pins(pin_in[w*WORD_W +: WORD_W]),
      .level(level), .rise_pulse(rise_p), .fall_pulse(fall_p)
    );

    gpio_bank_word #(.W(WORD_W)) u_word (
      .clk(clk), .rst(rst), .wr_en(reg_wr), .wdata(reg_wdata),
      .sel_dir(sel[FEAT_DIR]), .sel_set(sel[FEAT_SET]), .sel_clr(sel[FEAT_CLR]),
      .sel_rise(sel[FEAT_RISE]), .sel_fall(sel[FEAT_FALL]), .sel_stat(sel[FEAT_STAT]),
      .rise_pulse(rise_p), .fall_pulse(fall_p),
      .dir_q(dir_w), .out_q(out_w), .rise_en_q(ren_w), .fall_en_q(fen_w),
      .status_q(st_q), .status_d(st_d)
    );

    assign pin_oe [w*WORD_W +: WORD_W] = dir_w;
    assign pin_out[w*WORD_W +: WORD_W] = out_w;
    assign stat_any_d[w] = |st_d;
    assign stat_any_q[w] = |st_q;

    assign feat_val[FEAT_LEVEL][w] = level;
    assign feat_val[FEAT_DIR][w]   = dir_w;
    assign feat_val[FEAT_SET][w]   = '0;
    assign feat_val[FEAT_CLR][w]   = '0;
    assign feat_val[FEAT_RISE][w]  = ren_w;
    assign feat_val[FEAT_FALL][w]  = fen_w;
    assign feat_val[FEAT_STAT][w]  = st_q;
  end

  always_comb begin
    rd_mux = '0;
    for (int f = 0; f < NUM_FEAT; f++)
      for (int w = 0; w < WPF; w++)
        if (addr_ok && word_idx == WIDX_W'(f * WPF + w))
          rd_mux = feat_val[f][w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= |stat_any_d;
    end
  end

  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq == (|stat_any_q)); // R10
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (!irq && reg_rdata == '0 && pin_oe == '0 && pin_out == '0)); // R1
endmodule

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int NP  = 64;
  localparam int WPF = NP / 32;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe, pin_out;
  logic          irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_dir [WPF];
  logic [31:0] m_out [WPF];
  logic [31:0] m_ren [WPF];
  logic [31:0] m_fen [WPF];
  logic [31:0] m_st  [WPF];

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
  );

  function automatic logic [AW-1:0] adr(int f, int w);
    return AW'((f * WPF + w) * 4);
  endfunction

  function automatic logic [31:0] expect_word(int f, int w);
    case (f)
      0: return pin_in[w*32 +: 32];
      1: return m_dir[w];
      4: return m_ren[w];
      5: return m_fen[w];
      6: return m_st[w];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic any_status();
    logic a = 1'b0;
    for (int w = 0; w < WPF; w++) a |= |m_st[w];
    return a;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic model_write(int f, int w, logic [31:0] d);
    case (f)
      1: m_dir[w] = d;
      2: m_out[w] = m_out[w] | d;
      3: m_out[w] = m_out[w] & ~d;
      4: m_ren[w] = d;
      5: m_fen[w] = d;
      6: m_st[w]  = m_st[w] & ~d;
      default: ;
    endcase
  endtask

  task automatic change_pins(logic [NP-1:0] nv);
    logic [NP-1:0] old;
    old = pin_in;
    @(negedge clk);
    pin_in = nv;
    for (int w = 0; w < WPF; w++)
      m_st[w] |= (nv[w*32 +: 32] & ~old[w*32 +: 32] & m_ren[w]) |
                 (~nv[w*32 +: 32] & old[w*32 +: 32] & m_fen[w]);
    repeat (4) @(negedge clk);
  endtask

  task automatic verify_all(string tag);
    logic [31:0] d;
    for (int f = 0; f < 7; f++)
      for (int w = 0; w < WPF; w++) begin
        rd(adr(f, w), d);
        chk($sformatf("%s R2 R12 f%0d w%0d", tag, f, w), 64'(d), 64'(expect_word(f, w)));
      end
    for (int w = 0; w < WPF; w++) begin
      chk({tag, " R3 pin_oe"}, 64'(pin_oe[w*32 +: 32]), 64'(m_dir[w]));
      chk({tag, " R4 R5 pin_out"}, 64'(pin_out[w*32 +: 32]), 64'(m_out[w]));
    end
    chk({tag, " R10 irq"}, 64'(irq), 64'(any_status()));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int w = 0; w < WPF; w++) begin
      m_dir[w] = '0; m_out[w] = '0; m_ren[w] = '0; m_fen[w] = '0; m_st[w] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", 64'(pin_oe), 64'h0);
    chk("R1 pin_out", 64'(pin_out), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 rdata", 64'(reg_rdata), 64'h0);
    verify_all("R1");

    // R6 level write ignored
    change_pins(64'h0000_00F0_0000_000F);
    wr(adr(0, 0), 32'hFFFF_FFFF);
    rd(adr(0, 0), d);
    chk("R6 level write ignored", 64'(d), 64'h0000_000F);
    rd(adr(0, 1), d);
    chk("R6 level word1", 64'(d), 64'h0000_00F0);

    // R2 misaligned and out-of-range accesses ignored
    wr(adr(1, 0) | AW'(1), 32'hA5A5_A5A5);
    rd(adr(1, 0), d);
    chk("R2 misaligned write ignored", 64'(d), 64'h0);
    rd(adr(1, 1) | AW'(2), d);
    chk("R2 misaligned read zero", 64'(d), 64'h0);
    wr(adr(7, 0), 32'hFFFF_FFFF);
    rd(adr(7, 0), d);
    chk("R2 beyond last word reads zero", 64'(d), 64'h0);
    chk("R2 out of range no pin effect", 64'({pin_oe, pin_out} != 0), 64'h0);

    // R11 latch held while input
    wr(adr(2, 1), 32'h0000_0100); model_write(2, 1, 32'h0000_0100);
    chk("R11 latch set while input", 64'(pin_out[40]), 64'h1);
    chk("R11 oe still off", 64'(pin_oe[40]), 64'h0);
    wr(adr(1, 1), 32'h0000_0100); model_write(1, 1, 32'h0000_0100);
    chk("R11 output drives last value", 64'({pin_oe[40], pin_out[40]}), 64'h3);
    rd(adr(2, 1), d);
    chk("R4 set word reads zero", 64'(d), 64'h0);

    // R7 both enables: either edge
    wr(adr(4, 0), 32'h1); model_write(4, 0, 32'h1);
    wr(adr(5, 0), 32'h1); model_write(5, 0, 32'h1);
    change_pins(pin_in & ~64'h1);
    rd(adr(6, 0), d);
    chk("R7 falling edge with both enables", 64'(d[0]), 64'h1);
    chk("R10 irq on status", 64'(irq), 64'h1);
    // R8 writing zero leaves status
    wr(adr(6, 0), 32'h0);
    rd(adr(6, 0), d);
    chk("R8 zero write keeps status", 64'(d[0]), 64'h1);

    // R9 coincident edge and clear
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk);
    wr(adr(6, 0), 32'h1);
    rd(adr(6, 0), d);
    chk("R9 edge with clear keeps bit", 64'(d[0]), 64'h1);
    chk("R9 irq stays", 64'(irq), 64'h1);
    wr(adr(6, 0), 32'h1); model_write(6, 0, 32'h1);
    rd(adr(6, 0), d);
    chk("R8 clear by writing one", 64'(d[0]), 64'h0);
    chk("R10 irq drops", 64'(irq), 64'h0);
    verify_all("directed");

    // constrained random mix
    for (int it = 0; it < 150; it++) begin
      int op;
      op = int'($urandom_range(0, 3));
      if (op == 0) begin
        change_pins({$urandom, $urandom});
      end else if (op == 1) begin
        int w;
        w = int'($urandom_range(0, WPF - 1));
        wr(adr(6, w), $urandom); model_write(6, w, reg_wdata);
      end else begin
        int f, w;
        logic [31:0] v;
        f = int'($urandom_range(1, 5));
        w = int'($urandom_range(0, WPF - 1));
        v = $urandom & $urandom;
        wr(adr(f, w), v); model_write(f, w, v);
      end
      if (it % 10 == 9) verify_all("random R7 R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule